// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block turns the system clock into the timing strobes that a UART transmitter and receiver consume. Its main output is a one-cycle strobe at sixteen times the bit rate. A second strobe marks every sixteenth of those, which gives one pulse per bit period. Software programs a 16-bit rate value and a mode bit, and then sets the run enable.

Two methods are available. With the mode bit low, the rate value is an integer divisor equal to clock / (16 × baud), and a counter fires each time it has counted that many clocks. With the mode bit high, the rate value is a phase increment equal to baud × 16 × 2^16 / clock. A 16-bit accumulator adds this increment on every clock, and each carry out of the top bit is one strobe. This fractional method is intended for rates above 19200 bit/s, where an integer divisor is too coarse.

Clearing the run enable halts the generator and returns all of its counting state to zero. Software clears it before it changes the rate, so that the first strobe after a restart arrives at a known time.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and afterwards for as long as run stays low, os_tick_o and bit_tick_o are both 0.
- R2: In integer mode (frac_mode_i = 0) with a divisor N ≥ 2, os_tick_o is a one-cycle pulse that repeats exactly every N clocks.
- R3: In integer mode, a divisor of 0 or 1 makes os_tick_o high on every clock while run is high.
- R4: After run rises in integer mode with divisor N, the first os_tick_o appears after the N-th rising edge at which run is sampled high.
- R5: In fractional mode (frac_mode_i = 1), os_tick_o marks each carry out of a 16-bit accumulator that starts at zero and adds rate_i on every clock. Over M clocks after run rises, the number of strobes is floor(M × rate_i / 65536), and a rate_i of 0 gives no strobes.
- R6: A clock edge that samples run low forces os_tick_o to 0 in the next cycle. It also clears the divider and the accumulator, so that a restart behaves as described in R4 and R5.
- R7: bit_tick_o is high only in the same cycle as os_tick_o, and only on every 16th os_tick_o counted since run rose.
- R8: Run low also clears the oversample sub-counter, so that after a restart the first bit_tick_o falls on the 16th os_tick_o again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_i | input | 1 | Run enable; when low, the generator is stopped and cleared |
| frac_mode_i | input | 1 | 0 selects the integer divisor, 1 selects the phase accumulator |
| rate_i | input | 16 | Divisor (integer mode) or phase increment (fractional mode) |
| os_tick_o | output | 1 | One-cycle strobe at 16 times the bit rate |
| bit_tick_o | output | 1 | One-cycle strobe on every 16th oversample strobe |

## Verification
Two events can land in the same cycle. The first is the bit strobe and the 16th oversample strobe, which are meant to coincide. The second is the clearing of run and a strobe that is already due. A fast integer divisor of 2 produces many 16-tick groups quickly, and the bench checks that the cycle of each bit strobe also holds an oversample strobe and falls on tick 16, 32 and so on. For the second case, run is dropped in the middle of a group. The bench checks that no strobe follows, and then that the restart places the first oversample strobe and the first bit strobe as if the block had just left reset.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DEF_RATE_W = 16;
  localparam int unsigned DEF_OVS    = 16;
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/baud_int_div.sv
module baud_int_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         tick_q, tick_d;
  logic         hit;
  logic         upd;

  always_comb begin
    hit    = (div_i <= ONE) || (cnt_q >= (div_i - ONE));
    tick_d = en_i & hit;
    if (!en_i)    cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_q + ONE;
    upd    = en_i | (cnt_q != '0) | tick_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] inc_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q, acc_d;
  logic         tick_q, tick_d;
  logic [W:0]   sum;
  logic         upd;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, inc_i};
    acc_d  = en_i ? sum[W-1:0] : '0;
    tick_d = en_i & sum[W];
    upd    = en_i | (acc_q != '0) | tick_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (upd) begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned RATIO = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic os_tick_i,
  output logic bit_tick_o
);
  localparam int unsigned SW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [SW-1:0] LAST = SW'(RATIO - 1);
  localparam logic [SW-1:0] ONE  = SW'(1);

  logic [SW-1:0] sub_q, sub_d;
  logic          at_last;
  logic          upd;

  always_comb begin
    at_last = (sub_q == LAST);
    upd     = !run_i | os_tick_i;
    if (!run_i)       sub_d = '0;
    else if (at_last) sub_d = '0;
    else              sub_d = sub_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sub_q <= '0;
    else if (upd) sub_q <= sub_d;
  end

  assign bit_tick_o = os_tick_i & at_last;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned RATE_W    = DEF_RATE_W,
  parameter int unsigned OVS_RATIO = DEF_OVS,
  parameter int unsigned SYNC_LEN  = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              frac_mode_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              os_tick_o,
  output logic              bit_tick_o
);
  logic rst_n_sync;
  logic div_en, acc_en;
  logic div_tick, acc_tick;

  baud_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  assign div_en = run_i & ~frac_mode_i;
  assign acc_en = run_i &  frac_mode_i;

  baud_int_div #(.W(RATE_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .en_i   (div_en),
    .div_i  (rate_i),
    .tick_o (div_tick)
  );

  baud_phase_acc #(.W(RATE_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .en_i   (acc_en),
    .inc_i  (rate_i),
    .tick_o (acc_tick)
  );

  assign os_tick_o = frac_mode_i ? acc_tick : div_tick;

  baud_bit_div #(.RATIO(OVS_RATIO)) u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .run_i      (run_i),
    .os_tick_i  (os_tick_o),
    .bit_tick_o (bit_tick_o)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned RATE_W = 16
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              run_i,
  input logic              frac_mode_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              os_tick_o,
  input logic              bit_tick_o
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);
  localparam logic [RATE_W-1:0] TWO = RATE_W'(2);

  AST_STOP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !run_i |=> !os_tick_o); // R6

  AST_FAST_DIV: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && !frac_mode_i && rate_i <= ONE) |=> os_tick_o); // R3

  AST_DIV_GAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (os_tick_o && run_i && !frac_mode_i && rate_i >= TWO) |=> !os_tick_o); // R2

  AST_ZERO_INC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && frac_mode_i && rate_i == '0) |=> !os_tick_o); // R5

  AST_BIT_IN_OS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    bit_tick_o |-> os_tick_o); // R7

  AST_BIT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    bit_tick_o |=> !bit_tick_o); // R7
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.RATE_W(RATE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_sync),
  .run_i       (run_i),
  .frac_mode_i (frac_mode_i),
  .rate_i      (rate_i),
  .os_tick_o   (os_tick_o),
  .bit_tick_o  (bit_tick_o)
);

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk;
  logic        rst_n;
  logic        run;
  logic        frac;
  logic [15:0] rate;
  logic        os_tick;
  logic        bit_tick;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  baud_tick_gen dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .run_i       (run),
    .frac_mode_i (frac),
    .rate_i      (rate),
    .os_tick_o   (os_tick),
    .bit_tick_o  (bit_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Stops the block, programs it, raises run and observes `cycles` samples,
  // each taken at the falling edge after rising edge number i.
  task automatic measure(input bit f, input logic [15:0] r, input int cycles,
                         output int first, output int count,
                         output int mingap, output int maxgap,
                         output int bits, output int first_bit,
                         output int stray_bits);
    int last;
    @(negedge clk); run = 1'b0;
    repeat (2) @(negedge clk);
    frac = f; rate = r; run = 1'b1;
    first = -1; count = 0; mingap = 1 << 30; maxgap = 0;
    bits = 0; first_bit = -1; stray_bits = 0; last = 0;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (os_tick) begin
        count++;
        if (first < 0) first = i;
        else begin
          if (i - last < mingap) mingap = i - last;
          if (i - last > maxgap) maxgap = i - last;
        end
        last = i;
      end
      if (bit_tick) begin
        bits++;
        if (first_bit < 0) first_bit = i;
        if (!os_tick || (count % 16) != 0) stray_bits++;
      end
    end
  endtask

  task automatic t_reset();
    int seen = 0;
    rst_n = 1'b0; run = 1'b0; frac = 1'b0; rate = 16'd4;
    repeat (3) @(negedge clk);
    chk("R1 os_tick in reset", int'(os_tick), 0);
    chk("R1 bit_tick in reset", int'(bit_tick), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) seen++;
    end
    chk("R1 idle strobes with run low", seen, 0);
  endtask

  task automatic t_int(input logic [15:0] n, input int cycles);
    int f, c, mn, mx, b, fb, sb;
    measure(1'b0, n, cycles, f, c, mn, mx, b, fb, sb);
    chk($sformatf("R4 first tick div=%0d", n), f, int'(n));
    chk($sformatf("R2 tick count div=%0d", n), c, cycles / int'(n));
    chk($sformatf("R2 min gap div=%0d", n), mn, int'(n));
    chk($sformatf("R2 max gap div=%0d", n), mx, int'(n));
  endtask

  task automatic t_int_fast(input logic [15:0] n);
    int f, c, mn, mx, b, fb, sb;
    measure(1'b0, n, 64, f, c, mn, mx, b, fb, sb);
    chk($sformatf("R3 every-cycle count div=%0d", n), c, 64);
    chk($sformatf("R3 first tick div=%0d", n), f, 1);
  endtask

  task automatic t_frac(input logic [15:0] r, input int cycles);
    int f, c, mn, mx, b, fb, sb;
    longint exp;
    exp = (longint'(cycles) * longint'(r)) >> 16;
    measure(1'b1, r, cycles, f, c, mn, mx, b, fb, sb);
    chk($sformatf("R5 carry count inc=0x%04h", r), c, int'(exp));
    if (r == 16'h8000) begin
      chk("R5 first carry inc=0x8000", f, 2);
      chk("R5 gap inc=0x8000", mx, 2);
    end
  endtask

  task automatic t_bits();
    int f, c, mn, mx, b, fb, sb;
    measure(1'b0, 16'd2, 200, f, c, mn, mx, b, fb, sb);
    chk("R7 first bit strobe", fb, 32);
    chk("R7 bit strobe count", b, 100 / 16);
    chk("R7 bit strobe off 16th tick", sb, 0);
  endtask

  task automatic t_stop_restart();
    int f, c, mn, mx, b, fb, sb;
    int seen = 0;
    measure(1'b0, 16'd3, 20, f, c, mn, mx, b, fb, sb);
    chk("R6 ticks before stop", c, 6);
    run = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) seen++;
    end
    chk("R6 strobes while stopped", seen, 0);
    frac = 1'b0; rate = 16'd3; run = 1'b1;
    f = -1; fb = -1; c = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (os_tick) begin c++; if (f < 0) f = i; end
      if (bit_tick && fb < 0) fb = i;
    end
    chk("R6 first tick after restart", f, 3);
    chk("R8 first bit strobe after restart", fb, 48);
    // run cleared in fractional mode, then restarted at a new increment
    measure(1'b1, 16'hC000, 7, f, c, mn, mx, b, fb, sb);
    measure(1'b1, 16'h8000, 8, f, c, mn, mx, b, fb, sb);
    chk("R6 accumulator restart first carry", f, 2);
    chk("R6 accumulator restart count", c, 4);
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_int(16'd5, 100);
    t_int(16'd37, 370);
    t_int_fast(16'd1);
    t_int_fast(16'd0);
    t_frac(16'h8000, 4096);
    t_frac(16'h1234, 4096);
    t_frac(16'hFFFF, 4096);
    t_frac(16'h0000, 512);
    t_bits();
    t_stop_restart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule